// File: doc/BRIEF.md
# Ping-Pong Predistortion Table Trainer

This block trains a complex-gain correction table for an amplifier linearizer by the least-mean-squares rule, using indirect learning. Each accepted input carries a predistorter output sample `u` and the matching amplifier feedback sample `y`, already aligned in time and normalised in gain. The block picks a table entry from the feedback envelope. It forms the error between `u` and the entry's coefficient applied to `y`, and adds a scaled correction to that entry.

The table has two banks. The active bank feeds the predistortion datapath through a read port. Every training write goes to the other bank, which is the shadow bank. When training is switched on, the block first copies the active bank into the shadow bank. A swap request hands the trained shadow bank to the datapath. The swap waits until any update or copy in progress has finished. With training switched off, the block works as a fixed table and ignores all feedback.

Coefficients and samples are signed Q2.14 numbers. Unity gain is 16384. The step size is a power of two, 2^-s, so applying it costs only an arithmetic shift.

Top module: `lms_table_adapter`

## Requirements
- R1: After reset, every entry of both banks holds (16384, 0), `bank_sel` is 0 and `swap_done` is 0.
- R2: The entry index is k = min((|y_re| + |y_im|) >> (DW-AW), 2^AW - 1). With the defaults DW=16 and AW=4 the shift is 12.
- R3: For an accepted pair, with c the shadow entry k, the block computes cy = (c·y) >>> 14 per component and e = u - cy. It then computes d_re = (e_re·y_re + e_im·y_im) >>> (14+s) and d_im = (e_im·y_re - e_re·y_im) >>> (14+s), and writes c + d back to shadow entry k. Here s is `step_shift` at acceptance.
- R4: Training writes reach only the shadow bank. For a fixed `rd_addr`, the `rd_re`/`rd_im` outputs from the active bank change only in a cycle where `swap_done` is high.
- R5: Each written component saturates at -32768 or 32767 and never wraps.
- R6: While `adapt_en` is low, the block accepts no sample and leaves both banks unchanged.
- R7: Training starts with a copy. This happens when `adapt_en` goes high, and after every swap made while `adapt_en` stays high. The copy takes 2^AW cycles and writes every active entry into the shadow bank. Samples presented during the copy are dropped.
- R8: A one-cycle `swap_req` pulse is held pending through any update or copy in progress. It is then served on the first idle clock: `bank_sel` toggles and `swap_done` is high for exactly that one cycle. In an idle cycle a swap takes priority over a sample.
- R9: A sample accepted at one rising edge is written at the next rising edge. A sample presented during that write cycle is dropped. Each update therefore takes two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adapt_en | input | 1 | High selects training, low selects fixed-table mode |
| step_shift | input | SW | Step-size exponent s (mu = 2^-s) |
| smp_valid | input | 1 | A sample pair is present this cycle |
| u_re | input | DW | Predistorter output, real part |
| u_im | input | DW | Predistorter output, imaginary part |
| y_re | input | DW | Normalised feedback, real part |
| y_im | input | DW | Normalised feedback, imaginary part |
| swap_req | input | 1 | Single-cycle request to exchange the banks |
| rd_addr | input | AW | Datapath read address into the active bank |
| bank_sel | output | 1 | Index of the active bank |
| swap_done | output | 1 | One-cycle pulse when a swap takes effect |
| rd_re | output | DW | Active-bank coefficient at `rd_addr`, real part |
| rd_im | output | DW | Active-bank coefficient at `rd_addr`, imaginary part |

## Verification
A wrong internal state shows up at the ports in two ways. A corrupted active bank shows up on `rd_re`/`rd_im` in the same cycle as the read, and the bench compares that port to its model on every clock while it sweeps addresses. A fault in the shadow bank, in the update arithmetic or in the copy stays hidden until the next swap, and it appears on the first read of that entry after `swap_done`. For this reason each training phase ends with a swap and a sweep. A faulty swap sequencer shows up as a `bank_sel` or `swap_done` edge one cycle away from where the model puts it.

// File: rtl/lms_tbl_pkg.sv
package lms_tbl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_COPY = 2'd1,
      ST_UPD  = 2'd2
   } lms_state_e;

   localparam int ACC_W = 48;
endpackage

// File: rtl/lms_env_index.sv
module lms_env_index #(
   parameter int DW = 16,
   parameter int AW = 4
) (
   input  logic signed [DW-1:0] y_re,
   input  logic signed [DW-1:0] y_im,
   output logic [AW-1:0]        idx
);
   localparam int DEPTH = 1 << AW;
   localparam int SH    = DW - AW;

   if (AW >= DW - 1) begin : g_bad_aw
      $error("lms_env_index: AW too large for DW");
   end

   logic signed [DW:0] x_re, x_im;
   logic [DW:0] a_re, a_im, mag, lvl;

   always_comb begin
      x_re = (DW+1)'(y_re);
      x_im = (DW+1)'(y_im);
      a_re = (x_re < 0) ? (DW+1)'(-x_re) : (DW+1)'(x_re);
      a_im = (x_im < 0) ? (DW+1)'(-x_im) : (DW+1)'(x_im);
      mag  = a_re + a_im;
      lvl  = mag >> SH;
      idx  = (lvl >= (DW+1)'(DEPTH)) ? AW'(DEPTH - 1) : lvl[AW-1:0];
   end
endmodule

// File: rtl/lms_coef_update.sv
module lms_coef_update
   import lms_tbl_pkg::*;
#(
   parameter int DW = 16,
   parameter int SW = 4
) (
   input  logic signed [DW-1:0] c_re,
   input  logic signed [DW-1:0] c_im,
   input  logic signed [DW-1:0] u_re,
   input  logic signed [DW-1:0] u_im,
   input  logic signed [DW-1:0] y_re,
   input  logic signed [DW-1:0] y_im,
   input  logic [SW-1:0]        shift,
   output logic signed [DW-1:0] n_re,
   output logic signed [DW-1:0] n_im
);
   localparam int FRAC = DW - 2;
   localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] MINV = -MAXV - 1;

   if (2 * DW + SW + 4 > ACC_W) begin : g_bad_acc
      $error("lms_coef_update: accumulator too narrow");
   end

   logic signed [ACC_W-1:0] cr, ci, ur, ui, yr, yi;
   logic signed [ACC_W-1:0] cy_re, cy_im, e_re, e_im, g_re, g_im, s_re, s_im;

   always_comb begin
      cr    = ACC_W'(c_re);
      ci    = ACC_W'(c_im);
      ur    = ACC_W'(u_re);
      ui    = ACC_W'(u_im);
      yr    = ACC_W'(y_re);
      yi    = ACC_W'(y_im);
      cy_re = (cr * yr - ci * yi) >>> FRAC;
      cy_im = (cr * yi + ci * yr) >>> FRAC;
      e_re  = ur - cy_re;
      e_im  = ui - cy_im;
      g_re  = (e_re * yr + e_im * yi) >>> (FRAC + int'(shift));
      g_im  = (e_im * yr - e_re * yi) >>> (FRAC + int'(shift));
      s_re  = cr + g_re;
      s_im  = ci + g_im;
      n_re  = (s_re > MAXV) ? MAXV[DW-1:0] : (s_re < MINV) ? MINV[DW-1:0] : s_re[DW-1:0];
      n_im  = (s_im > MAXV) ? MAXV[DW-1:0] : (s_im < MINV) ? MINV[DW-1:0] : s_im[DW-1:0];
   end
endmodule

// File: rtl/lms_bank_store.sv
module lms_bank_store #(
   parameter int DW = 16,
   parameter int AW = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bank_sel,
   input  logic [AW-1:0]        p_addr,
   input  logic [AW-1:0]        q_addr,
   input  logic                 wr_en,
   input  logic signed [DW-1:0] wr_re,
   input  logic signed [DW-1:0] wr_im,
   output logic signed [DW-1:0] act_p_re,
   output logic signed [DW-1:0] act_p_im,
   output logic signed [DW-1:0] act_q_re,
   output logic signed [DW-1:0] act_q_im,
   output logic signed [DW-1:0] shd_q_re,
   output logic signed [DW-1:0] shd_q_im
);
   localparam int DEPTH = 1 << AW;
   localparam logic [DW-1:0] UNITY = DW'(1 << (DW - 2));

   logic [1:0][DW-1:0] p_re_b, p_im_b, q_re_b, q_im_b;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      localparam logic MINE = (b == 1);
      logic [DW-1:0] m_re [DEPTH];
      logic [DW-1:0] m_im [DEPTH];
      logic we;

      assign we = wr_en && (bank_sel != MINE);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
               m_re[i] <= UNITY;
               m_im[i] <= '0;
            end
         end else if (we) begin
            m_re[q_addr] <= wr_re;
            m_im[q_addr] <= wr_im;
         end
      end

      assign p_re_b[b] = m_re[p_addr];
      assign p_im_b[b] = m_im[p_addr];
      assign q_re_b[b] = m_re[q_addr];
      assign q_im_b[b] = m_im[q_addr];
   end

   assign act_p_re = p_re_b[bank_sel];
   assign act_p_im = p_im_b[bank_sel];
   assign act_q_re = q_re_b[bank_sel];
   assign act_q_im = q_im_b[bank_sel];
   assign shd_q_re = q_re_b[~bank_sel];
   assign shd_q_im = q_im_b[~bank_sel];
endmodule

// File: rtl/lms_table_adapter.sv
module lms_table_adapter
   import lms_tbl_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 4,
   parameter int SW = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adapt_en,
   input  logic [SW-1:0]        step_shift,
   input  logic                 smp_valid,
   input  logic signed [DW-1:0] u_re,
   input  logic signed [DW-1:0] u_im,
   input  logic signed [DW-1:0] y_re,
   input  logic signed [DW-1:0] y_im,
   input  logic                 swap_req,
   input  logic [AW-1:0]        rd_addr,
   output logic                 bank_sel,
   output logic                 swap_done,
   output logic signed [DW-1:0] rd_re,
   output logic signed [DW-1:0] rd_im
);
   localparam int DEPTH = 1 << AW;

   if (DW < 8 || DW > 20) begin : g_bad_dw
      $error("lms_table_adapter: DW out of range");
   end
   if (SW < 1 || SW > 5) begin : g_bad_sw
      $error("lms_table_adapter: SW out of range");
   end

   lms_state_e state;
   logic [AW-1:0] cnt, k_q, k_now, q_addr;
   logic armed, pend, sel_q, done_q, swap_go, wr_en;
   logic signed [DW-1:0] u_re_q, u_im_q, y_re_q, y_im_q;
   logic [SW-1:0] s_q;
   logic signed [DW-1:0] act_q_re, act_q_im, shd_q_re, shd_q_im;
   logic signed [DW-1:0] new_re, new_im, wr_re, wr_im;

   lms_env_index #(.DW(DW), .AW(AW)) u_index (
      .y_re(y_re), .y_im(y_im), .idx(k_now)
   );

   assign swap_go = (state == ST_IDLE) && (pend || swap_req);
   assign q_addr  = (state == ST_COPY) ? cnt : k_q;
   assign wr_en   = (state == ST_COPY) || (state == ST_UPD);
   assign wr_re   = (state == ST_COPY) ? act_q_re : new_re;
   assign wr_im   = (state == ST_COPY) ? act_q_im : new_im;

   lms_coef_update #(.DW(DW), .SW(SW)) u_update (
      .c_re(shd_q_re), .c_im(shd_q_im), .u_re(u_re_q), .u_im(u_im_q),
      .y_re(y_re_q), .y_im(y_im_q), .shift(s_q), .n_re(new_re), .n_im(new_im)
   );

   lms_bank_store #(.DW(DW), .AW(AW)) u_store (
      .clk(clk), .rst_n(rst_n), .bank_sel(sel_q), .p_addr(rd_addr), .q_addr(q_addr),
      .wr_en(wr_en), .wr_re(wr_re), .wr_im(wr_im),
      .act_p_re(rd_re), .act_p_im(rd_im), .act_q_re(act_q_re), .act_q_im(act_q_im),
      .shd_q_re(shd_q_re), .shd_q_im(shd_q_im)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         k_q    <= '0;
         armed  <= 1'b0;
         pend   <= 1'b0;
         sel_q  <= 1'b0;
         done_q <= 1'b0;
         u_re_q <= '0;
         u_im_q <= '0;
         y_re_q <= '0;
         y_im_q <= '0;
         s_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (swap_go) pend <= 1'b0;
         else if (swap_req) pend <= 1'b1;
         unique case (state)
            ST_IDLE: begin
               if (swap_go) begin
                  sel_q  <= ~sel_q;
                  done_q <= 1'b1;
                  armed  <= 1'b0;
                  cnt    <= '0;
                  state  <= adapt_en ? ST_COPY : ST_IDLE;
               end else if (adapt_en && !armed) begin
                  cnt   <= '0;
                  state <= ST_COPY;
               end else if (adapt_en && smp_valid) begin
                  u_re_q <= u_re;
                  u_im_q <= u_im;
                  y_re_q <= y_re;
                  y_im_q <= y_im;
                  k_q    <= k_now;
                  s_q    <= step_shift;
                  state  <= ST_UPD;
               end
            end
            ST_COPY: begin
               if (cnt == AW'(DEPTH - 1)) begin
                  state <= ST_IDLE;
                  armed <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_UPD:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
         if (!adapt_en) armed <= 1'b0;
      end
   end

   assign bank_sel  = sel_q;
   assign swap_done = done_q;

   AST_SEL_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_sel != $past(bank_sel)) |-> swap_done); // R8

   AST_SWAP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      swap_done |-> ($past(state) == ST_IDLE)); // R8

   AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!swap_done && $stable(rd_addr)) |-> ($stable(rd_re) && $stable(rd_im))); // R4

   AST_UPDATE_NEEDS_ADAPT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_UPD) |-> $past(adapt_en)); // R6

   AST_COPY_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_COPY) && ($past(state) == ST_COPY)) |-> (cnt == $past(cnt) + 1'b1)); // R7
endmodule

// File: tb/lms_table_adapter_test.sv
`timescale 1ns/1ps
module lms_table_adapter_test;
   localparam int DW = 16, AW = 4, SW = 4, DEPTH = 16, ONE = 16384;

   logic clk = 1'b0, rst_n = 1'b0, adapt_en = 1'b0, smp_valid = 1'b0, swap_req = 1'b0;
   logic [SW-1:0] step_shift = '0;
   logic signed [DW-1:0] u_re = '0, u_im = '0, y_re = '0, y_im = '0;
   logic [AW-1:0] rd_addr = '0;
   logic bank_sel, swap_done;
   logic signed [DW-1:0] rd_re, rd_im;

   lms_table_adapter #(.DW(DW), .AW(AW), .SW(SW)) uut (
      .clk(clk), .rst_n(rst_n), .adapt_en(adapt_en), .step_shift(step_shift),
      .smp_valid(smp_valid), .u_re(u_re), .u_im(u_im), .y_re(y_re), .y_im(y_im),
      .swap_req(swap_req), .rd_addr(rd_addr), .bank_sel(bank_sel),
      .swap_done(swap_done), .rd_re(rd_re), .rd_im(rd_im)
   );

   always #2 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   // behavioural model state
   int m_re [2][DEPTH];
   int m_im [2][DEPTH];
   int m_mode = 0, m_cnt = 0, m_k = 0, m_s = 0;
   int m_u_re = 0, m_u_im = 0, m_y_re = 0, m_y_im = 0;
   bit m_sel = 0, m_done = 0, m_armed = 0, m_pend = 0;
   int seed = 12345;

   task automatic chk(string req, longint act, longint exp, string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int sat16(longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return int'(v);
   endfunction

   function automatic int idx_of(int yr, int yi);
      int a;
      a = (yr < 0 ? -yr : yr) + (yi < 0 ? -yi : yi);
      a = a >> (DW - AW);
      return (a > DEPTH - 1) ? DEPTH - 1 : a;
   endfunction

   function automatic int rnd(int span);
      seed = seed * 1103515245 + 12345;
      return ((seed >>> 8) & 32'h7fffffff) % span;
   endfunction

   task automatic model_reset();
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < DEPTH; i++) begin
            m_re[b][i] = ONE;
            m_im[b][i] = 0;
         end
      m_mode = 0; m_cnt = 0; m_sel = 0; m_done = 0; m_armed = 0; m_pend = 0;
   endtask

   task automatic model_update();
      int w;
      longint cr, ci, yr, yi, cyr, cyi, er, ei, dr, di;
      w  = m_sel ? 0 : 1;
      cr = m_re[w][m_k]; ci = m_im[w][m_k]; yr = m_y_re; yi = m_y_im;
      cyr = (cr * yr - ci * yi) >>> 14;
      cyi = (cr * yi + ci * yr) >>> 14;
      er  = longint'(m_u_re) - cyr;
      ei  = longint'(m_u_im) - cyi;
      dr  = (er * yr + ei * yi) >>> (14 + m_s);
      di  = (ei * yr - er * yi) >>> (14 + m_s);
      m_re[w][m_k] = sat16(cr + dr);
      m_im[w][m_k] = sat16(ci + di);
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         m_done = 0;
         case (m_mode)
            0: begin
               if (m_pend || swap_req) begin
                  m_sel = ~m_sel; m_done = 1; m_pend = 0; m_armed = 0; m_cnt = 0;
                  m_mode = adapt_en ? 1 : 0;
               end else if (adapt_en && !m_armed) begin
                  m_cnt = 0; m_mode = 1;
               end else if (adapt_en && smp_valid) begin
                  m_u_re = u_re; m_u_im = u_im; m_y_re = y_re; m_y_im = y_im;
                  m_k = idx_of(y_re, y_im); m_s = int'(step_shift); m_mode = 2;
               end
            end
            1: begin
               m_re[m_sel ? 0 : 1][m_cnt] = m_re[m_sel][m_cnt];
               m_im[m_sel ? 0 : 1][m_cnt] = m_im[m_sel][m_cnt];
               if (swap_req) m_pend = 1;
               if (m_cnt == DEPTH - 1) begin m_mode = 0; m_armed = 1; end
               else m_cnt++;
            end
            default: begin
               model_update();
               if (swap_req) m_pend = 1;
               m_mode = 0;
            end
         endcase
         if (!adapt_en) m_armed = 0;
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R8", bank_sel, m_sel, "bank_sel");
         chk("R8", swap_done, m_done, "swap_done");
         chk("R4", rd_re, m_re[m_sel][rd_addr], "rd_re");
         chk("R4", rd_im, m_im[m_sel][rd_addr], "rd_im");
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
      smp_valid = 1'b0;
      swap_req  = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) step();
   endtask

   task automatic send(int ur, int ui, int yr, int yi);
      u_re = DW'(ur); u_im = DW'(ui); y_re = DW'(yr); y_im = DW'(yi);
      smp_valid = 1'b1;
      step();
   endtask

   task automatic swap();
      swap_req = 1'b1;
      step();
   endtask

   task automatic read_at(string req, int a, int exp_re, int exp_im);
      rd_addr = AW'(a);
      @(negedge clk);
      chk(req, rd_re, exp_re, "entry re");
      chk(req, rd_im, exp_im, "entry im");
      @(posedge clk);
      #1;
   endtask

   task automatic sweep();
      for (int a = 0; a < DEPTH; a++) begin
         rd_addr = AW'(a);
         step();
      end
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      model_reset();
      idle(3);
      rst_n = 1'b1;
      #1;
      // R1: reset contents and outputs
      @(negedge clk);
      chk("R1", bank_sel, 0, "bank_sel after reset");
      chk("R1", swap_done, 0, "swap_done after reset");
      @(posedge clk); #1;
      for (int a = 0; a < DEPTH; a++) read_at("R1", a, ONE, 0);

      // R6: fixed-table mode ignores feedback
      step_shift = 4'd0;
      for (int i = 0; i < 8; i++) send(-20000, 15000, 3000 * i, -2000 * i);
      swap();
      for (int a = 0; a < DEPTH; a++) read_at("R6", a, ONE, 0);
      swap();
      for (int a = 0; a < DEPTH; a++) read_at("R6", a, ONE, 0);

      // R7: enable training; a sample during the copy is dropped
      adapt_en = 1'b1;
      step_shift = 4'd2;
      send(32000, 32000, 16384, 0);
      idle(18);
      // R3: single hand-computed update of entry 4
      send(20480, 0, 16384, 0);
      idle(2);
      read_at("R4", 4, ONE, 0);
      swap();
      read_at("R3", 4, 17408, 0);
      // R8: swap during copy is held until the copy ends
      swap();
      idle(20);
      chk("R8", bank_sel, 0, "bank_sel after deferred swap");
      read_at("R7", 4, 17408, 0);

      // R2: envelope 30000 selects entry 7
      idle(18);
      step_shift = 4'd3;
      send(5000, -3000, 20000, -10000);
      idle(2);
      swap();
      read_at("R2", 7, 13561, -77);
      read_at("R2", 6, ONE, 0);
      read_at("R2", 8, ONE, 0);

      // R5: both components saturate on entry 6
      idle(18);
      step_shift = 4'd0;
      send(-32768, 32767, 0, -28000);
      idle(2);
      swap();
      read_at("R5", 6, -32768, -32768);

      // R8: swap requested in the write cycle is served one clock later
      idle(18);
      send(1000, 1000, 8000, 8000);
      swap_req = 1'b1;
      @(negedge clk);
      chk("R8", swap_done, 0, "no swap during write");
      step();
      @(negedge clk);
      chk("R8", swap_done, 0, "swap waits one more edge");
      step();
      @(negedge clk);
      chk("R8", swap_done, 1, "swap after write");
      step();
      @(negedge clk);
      chk("R8", swap_done, 0, "swap pulse one cycle");
      step();

      // R9: back-to-back samples, half dropped; periodic swaps
      idle(18);
      for (int i = 0; i < 400; i++) begin
         u_re = DW'(rnd(60000) - 30000);
         u_im = DW'(rnd(60000) - 30000);
         y_re = DW'(rnd(60000) - 30000);
         y_im = DW'(rnd(60000) - 30000);
         step_shift = SW'(3 + rnd(8));
         rd_addr = AW'(rnd(DEPTH));
         smp_valid = 1'b1;
         if (i % 97 == 96) swap_req = 1'b1;
         step();
      end
      idle(20);
      // R9: the burst result, read back through both banks
      adapt_en = 1'b0;
      step();
      swap();
      sweep();
      swap();
      sweep();
      for (int a = 0; a < DEPTH; a++) read_at("R9", a, m_re[m_sel][a], m_im[m_sel][a]);
      summary();
   end
endmodule